// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software through a 12-bit down counter. The counter is advanced by a low-speed tick enable. A power-of-two prescaler sits between the tick and the counter. Software must service the counter ("kick") inside a permitted window, and the window is bounded by a programmable delta value.

A fault is raised in either of two cases:
- the counter expires, or
- a kick arrives too early, while the count is still at or above the delta value.

A mode bit selects how a fault is delivered. It is either a sticky interrupt or a one-cycle reset request for the system reset controller.

The configuration, reload-value and delta registers are guarded by an unlock key. A debug-halt input freezes counting so that a halted processor is not reset.

Top module: `wwdt_core`

## Requirements
- R1: After reset the count output is 0xFFF, the interrupt and reset outputs are 0, the timer is disabled and the protected registers are locked.
- R2: Writes use `wr_sel_i` codes: 0 lock key, 1 configuration, 2 reload value, 3 delta value, 4 kick, 5 fault clear. The configuration bits are: [2:0] prescale p, [3] fault mode (0 interrupt, 1 reset), [4] enable.
- R3: While enabled, the count decreases by one every 2^p tick pulses. Enabling a disabled timer loads the count from the reload value and restarts the prescaler.
- R4: A tick step taken at count 0 raises a fault and reloads the count from the reload value.
- R5: Writing 0x5FA0 to the kick register while the count is below the delta value reloads the count and raises no fault.
- R6: Writing 0x5FA0 to the kick register while the count is greater than or equal to the delta value reloads the count and raises a fault.
- R7: A kick write with any value other than 0x5FA0 is ignored: the count keeps running and no fault is raised.
- R8: In fault mode 0 a fault sets `irq_o`, which stays set until a write to the fault-clear register. In mode 1 a fault drives `rst_o` high for exactly one cycle and leaves `irq_o` at 0.
- R9: While `dbg_halt_i` is high, the count and the prescaler phase do not advance.
- R10: Writes to the configuration, reload and delta registers are ignored while locked. Writing 0x35CA to the lock register unlocks them, and writing any other value relocks them.
- R11: While disabled, the count does not change on tick pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse from the low-speed clock domain |
| dbg_halt_i | input | 1 | Processor halted in debug; freezes counting |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select code |
| wr_data_i | input | 16 | Write data |
| count_o | output | 12 | Current counter value |
| irq_o | output | 1 | Sticky fault interrupt |
| rst_o | output | 1 | One-cycle fault reset request |

## Verification
The hardest case to reach is a kick landing exactly on the window edge, where the count equals the delta value. The prescaler phase and the count must both be known at the moment of the write. The stimulus gets there by re-enabling the timer before every vector, which reloads the count and zeroes the prescaler. It then issues an exact number of tick pulses, so the count at the kick is known. Paired vectors kick one tick on either side of the delta value. A short reload value brings about an expiry within a few ticks.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

    localparam int PRE_W  = 3;
    localparam int DATA_W = 16;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_LOCK   = 3'd0,
        SEL_CFG    = 3'd1,
        SEL_RELOAD = 3'd2,
        SEL_DELTA  = 3'd3,
        SEL_KICK   = 3'd4,
        SEL_CLEAR  = 3'd5
    } wwdt_sel_e;

    typedef struct packed {
        logic             en;
        logic             rst_mode;
        logic [PRE_W-1:0] presc;
    } wwdt_cfg_t;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 16'h35CA;
    localparam logic [DATA_W-1:0] KICK_KEY   = 16'h5FA0;

endpackage

// File: rtl/wwdt_prescale.sv
module wwdt_prescale
    import wwdt_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          run_i,
    input  logic          clr_i,
    input  logic [PW-1:0] shift_i,
    output logic          step_o
);
    localparam int DIV_W = (1 << PW) - 1;

    logic [DIV_W-1:0] div_q, div_d, lim;
    logic             hit;

    always_comb begin
        lim    = {DIV_W{1'b1}} >> (PW'(DIV_W) - shift_i);
        hit    = (div_q >= lim);
        step_o = run_i & tick_i & hit & ~clr_i;
        div_d  = div_q;
        if (clr_i) begin
            div_d = '0;
        end else if (run_i && tick_i) begin
            div_d = hit ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end
endmodule

// File: rtl/wwdt_regs.sv
module wwdt_regs
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output wwdt_cfg_t         cfg_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [CNT_W-1:0]  delta_o,
    output logic              unlocked_o,
    output logic              kick_o,
    output logic              start_o,
    output logic              clear_o
);
    typedef struct packed {
        wwdt_cfg_t        cfg;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] delta;
        logic             unlocked;
    } regs_t;

    regs_t     r_q, r_d;
    wwdt_cfg_t cfg_new;

    always_comb begin
        cfg_new = wwdt_cfg_t'(wr_data_i[PRE_W+1:0]);
        r_d     = r_q;
        kick_o  = wr_en_i && (wr_sel_i == SEL_KICK) && (wr_data_i == KICK_KEY);
        clear_o = wr_en_i && (wr_sel_i == SEL_CLEAR) && wr_data_i[0];
        start_o = wr_en_i && (wr_sel_i == SEL_CFG) && r_q.unlocked
                  && cfg_new.en && !r_q.cfg.en;
        if (wr_en_i) begin
            if (wr_sel_i == SEL_LOCK) begin
                r_d.unlocked = (wr_data_i == UNLOCK_KEY);
            end else if (r_q.unlocked) begin
                if (wr_sel_i == SEL_CFG)    r_d.cfg    = cfg_new;
                if (wr_sel_i == SEL_RELOAD) r_d.reload = wr_data_i[CNT_W-1:0];
                if (wr_sel_i == SEL_DELTA)  r_d.delta  = wr_data_i[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.cfg      <= '0;
            r_q.reload   <= '1;
            r_q.delta    <= '1;
            r_q.unlocked <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_o      = r_q.cfg;
    assign reload_o   = r_q.reload;
    assign delta_o    = r_q.delta;
    assign unlocked_o = r_q.unlocked;
endmodule

// File: rtl/wwdt_count.sv
module wwdt_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             rst_mode_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] delta_i,
    input  logic             kick_i,
    input  logic             start_i,
    input  logic             step_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o,
    output logic             rst_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             rst;
    } cnt_state_t;

    cnt_state_t s_q, s_d;
    logic       fault;

    always_comb begin
        s_d     = s_q;
        s_d.rst = 1'b0;
        fault   = 1'b0;
        if (start_i) begin
            s_d.cnt = reload_i;
        end else if (kick_i) begin
            s_d.cnt = reload_i;
            fault   = en_i && (s_q.cnt >= delta_i);
        end else if (step_i) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = reload_i;
                fault   = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (clear_i) s_d.irq = 1'b0;
        if (fault) begin
            if (rst_mode_i) s_d.rst = 1'b1;
            else            s_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cnt <= '1;
            s_q.irq <= 1'b0;
            s_q.rst <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o = s_q.cnt;
    assign irq_o   = s_q.irq;
    assign rst_o   = s_q.rst;
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              dbg_halt_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              irq_o,
    output logic              rst_o
);
    wwdt_cfg_t        cfg_w;
    logic [CNT_W-1:0] reload_w, delta_w;
    logic             unlocked_w, kick_w, start_w, clear_w, step_w;

    wwdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
        .cfg_o(cfg_w), .reload_o(reload_w), .delta_o(delta_w),
        .unlocked_o(unlocked_w), .kick_o(kick_w), .start_o(start_w),
        .clear_o(clear_w)
    );

    wwdt_prescale #(.PW(PRE_W)) u_pre (
        .clk_i, .rst_ni, .tick_i,
        .run_i(cfg_w.en & ~dbg_halt_i),
        .clr_i(kick_w | start_w),
        .shift_i(cfg_w.presc),
        .step_o(step_w)
    );

    wwdt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk_i, .rst_ni,
        .en_i(cfg_w.en), .rst_mode_i(cfg_w.rst_mode),
        .reload_i(reload_w), .delta_i(delta_w),
        .kick_i(kick_w), .start_i(start_w), .step_i(step_w),
        .clear_i(clear_w),
        .count_o, .irq_o, .rst_o
    );
endmodule

// File: rtl/wwdt_checks.sv
module wwdt_checks
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [SEL_W-1:0]  wr_sel_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              dbg_halt_i,
    input logic [CNT_W-1:0]  count_o,
    input logic              irq_o,
    input logic              rst_o,
    input logic              step_w,
    input logic              unlocked_w,
    input wwdt_cfg_t         cfg_w,
    input logic [CNT_W-1:0]  delta_w
);
    assert_step_by_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> (count_o == $past(count_o)) ||
                     (count_o == $past(count_o) - 1'b1) || ($past(count_o) == '0));

    assert_underflow_fault_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_w && count_o == '0 && !wr_en_i) |=> (irq_o || rst_o));

    assert_early_kick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i == SEL_KICK && wr_data_i == KICK_KEY && cfg_w.en
         && count_o >= delta_w) |=> (irq_o || rst_o));

    assert_halt_freezes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_halt_i && !wr_en_i) |=> $stable(count_o));

    assert_locked_cfg_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!unlocked_w && wr_en_i && wr_sel_i == SEL_CFG) |=> $stable(cfg_w));

    assert_one_channel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !($rose(irq_o) && rst_o));
endmodule

bind wwdt_core wwdt_checks #(.CNT_W(CNT_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .dbg_halt_i(dbg_halt_i), .count_o(count_o),
    .irq_o(irq_o), .rst_o(rst_o), .step_w(step_w), .unlocked_w(unlocked_w),
    .cfg_w(cfg_w), .delta_w(delta_w)
);

// File: tb/sim_wwdt_core.sv
`timescale 1ns/1ps
module sim_wwdt_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        halt = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [11:0] count;
    logic        irq, rst;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    wwdt_core u0 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .dbg_halt_i(halt),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .count_o(count), .irq_o(irq), .rst_o(rst)
    );

    typedef struct packed {
        logic [2:0]  p;
        logic [11:0] d;
        logic [11:0] r;
        logic [15:0] w;
        logic [15:0] key;
        logic [11:0] pre;
        logic [11:0] post;
        logic        irq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 12'h100, 12'h200, 16'd384, 16'h5FA0, 12'h080, 12'h200, 1'b0},
        '{3'd2, 12'h100, 12'h200, 16'd40,  16'h5FA0, 12'h1F6, 12'h200, 1'b1},
        '{3'd1, 12'h010, 12'h020, 16'd20,  16'h5FA0, 12'h016, 12'h020, 1'b1},
        '{3'd1, 12'h010, 12'h020, 16'd44,  16'h5FA0, 12'h00A, 12'h020, 1'b0},
        '{3'd0, 12'h010, 12'h040, 16'd5,   16'h1234, 12'h03B, 12'h03B, 1'b0},
        '{3'd0, 12'h004, 12'h008, 16'd9,   16'h0000, 12'h008, 12'h008, 1'b1},
        '{3'd3, 12'h800, 12'h7FF, 16'd16,  16'h5FA0, 12'h7FD, 12'h7FF, 1'b0},
        '{3'd0, 12'h030, 12'h040, 16'd16,  16'h5FA0, 12'h030, 12'h040, 1'b1},
        '{3'd0, 12'h030, 12'h040, 16'd17,  16'h5FA0, 12'h02F, 12'h040, 1'b0}
    };

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic setup(logic [2:0] p, logic mode, logic [11:0] d, logic [11:0] r);
        wr(3'd0, 16'h35CA);
        wr(3'd1, 16'h0000);
        wr(3'd2, {4'd0, r});
        wr(3'd3, {4'd0, d});
        wr(3'd1, {11'd0, 1'b1, mode, p});
        wr(3'd5, 16'h0001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 count", count, 12'hFFF);
        check("R1 irq", irq, 0);
        check("R1 rst", rst, 0);
        // R11 disabled: ticks have no effect
        ticks(5);
        check("R11 disabled hold", count, 12'hFFF);
        // R10 locked after reset: enable write ignored
        wr(3'd1, 16'h0010);
        ticks(3);
        check("R10 locked cfg ignored", count, 12'hFFF);
        // R10 relock by non-key value, reload write ignored
        wr(3'd0, 16'h35CA);
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0123);
        wr(3'd0, 16'h35CA);
        wr(3'd1, 16'h0010);
        check("R10 relocked reload ignored", count, 12'hFFF);

        // R2 R3 R5 R6 R7 R4 vector table
        for (int v = 0; v < NV; v++) begin
            setup(VECS[v].p, 1'b0, VECS[v].d, VECS[v].r);
            ticks(int'(VECS[v].w));
            check($sformatf("R3/R4 vec%0d count before kick", v), count, VECS[v].pre);
            wr(3'd4, VECS[v].key);
            check($sformatf("R5/R6/R7 vec%0d count after kick", v), count, VECS[v].post);
            check($sformatf("R4/R6/R8 vec%0d irq", v), irq, VECS[v].irq);
        end

        // R8 sticky irq cleared by fault-clear write
        setup(3'd0, 1'b0, 12'h010, 12'h040);
        wr(3'd4, 16'h5FA0);
        check("R8 irq set", irq, 1);
        ticks(2);
        check("R8 irq sticky", irq, 1);
        wr(3'd5, 16'h0001);
        check("R8 irq cleared", irq, 0);

        // R8 reset mode: one-cycle pulse, no irq
        setup(3'd0, 1'b1, 12'h010, 12'h040);
        wr(3'd4, 16'h5FA0);
        check("R8 rst pulse", rst, 1);
        check("R8 no irq in reset mode", irq, 0);
        @(negedge clk);
        check("R8 rst one cycle", rst, 0);

        // R9 debug halt freezes counting
        setup(3'd0, 1'b0, 12'h010, 12'h040);
        halt = 1'b1;
        ticks(10);
        check("R9 halted count", count, 12'h040);
        halt = 1'b0;
        ticks(3);
        check("R9 resumed count", count, 12'h03D);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule